// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge and Vector Unit

This block combines two eight-line interrupt resolver slices, a master and a slave, into a sixteen-line interrupt controller with one request output to the processor. Lines 0 to 7 enter the master slice and lines 8 to 15 enter the slave slice. Master line 2 carries no external source. It is the cascade input, and it is set by a one-shot pulse whenever the slave slice holds a winning request.

When the processor acknowledges, the block decides whether the master slice, the slave slice, both or neither take the interrupt into service. It then forms an 8-bit vector from the selected slice's 5-bit base and a 3-bit line index. It also reports the global line number (0 to 15) that was acknowledged, including the spurious cases, so that the end-of-service command can later address the same line.

The vector leaves as a valid pulse with no ready signal: the consumer must take it in the cycle after the acknowledge, and the block never applies or accepts back-pressure. Mask, trigger-mode and base values are plain control inputs. End of service is a strobe that carries a global line number.

Top module: `icu_cascade_ack`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `int_req` and `vec_valid` are 0.
- R2: A line with `level_sel` bit 0 latches a pending request on a 0-to-1 change of its input. A held-high input makes no new request after it has been acknowledged and ended. A line whose `irq_mask` bit is 1 raises no request, but its pending state is kept and shows once it is unmasked.
- R3: `int_req` is 1 exactly when the master slice has a winner. A slice's winner is its lowest-numbered unmasked pending line, and only when that number is lower than its lowest in-service line. A new request that outranks the line in service is therefore signalled, and a lower one is held back.
- R4: The cycle after the slave slice has a winner, master line 2 becomes pending as an edge request. Input `irq_in[2]` and `level_sel[2]` are ignored.
- R5: On `ack_stb` with a master winner other than 2, only the master is acknowledged. `vec_out` = {master_base, index} and `vec_line` = index.
- R6: On `ack_stb` with master winner 2 and a slave winner s, both slices are acknowledged (master on line 2). `vec_out` = {slave_base, s} and `vec_line` = 8 + s.
- R7: On `ack_stb` with master winner 2 and no slave winner, only master line 2 is acknowledged. `vec_out` = {slave_base, 3'd7} and `vec_line` = 15.
- R8: On `ack_stb` with no master winner, nothing is acknowledged. `vec_out` = {master_base, 3'd7} and `vec_line` = 7.
- R9: `vec_valid` is 1 for exactly the one cycle after each `ack_stb` cycle, with `vec_out` and `vec_line` registered alongside it. It is 0 otherwise.
- R10: `eoi_stb` clears the in-service bit addressed by `eoi_line`: bit 3 selects the slice (0 master, 1 slave) and bits 2:0 select the line within it.
- R11: Acknowledging an edge line clears its pending state. Acknowledging a line with `level_sel` bit 1 leaves it pending while its input stays high. If the acknowledge and another event hit the same pending bit in one cycle, the acknowledge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Interrupt inputs; bit 2 is unused (cascade) |
| irq_mask | input | 16 | 1 blocks the line from requesting |
| level_sel | input | 16 | 1 = level-sensitive line, 0 = edge |
| master_base | input | 5 | Upper vector bits for master lines |
| slave_base | input | 5 | Upper vector bits for slave lines |
| ack_stb | input | 1 | Single-cycle processor acknowledge |
| eoi_stb | input | 1 | Single-cycle end-of-service strobe |
| eoi_line | input | 4 | Global line ended by `eoi_stb` |
| int_req | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid pulse |
| vec_out | output | 8 | Acknowledged interrupt vector |
| vec_line | output | 4 | Acknowledged global line number |

## Verification
A single master line checks the plain vector path. Two master lines raised in turn, with one in service, tell preemption apart from blocking. A slave line whose edge crosses the cascade shows that the slave base and line 8 + index are chosen. A level slave line that drops before the acknowledge separates the slave spurious case from the master spurious case, which an acknowledge with nothing pending produces. A long stretch of random line activity, masks, acknowledges and end-of-service commands is then compared cycle by cycle against a behavioural model. It shows up mismatches in ordering, in same-cycle collisions and in the one-cycle delay of the cascade pulse.

// File: rtl/icu_cascade_pkg.sv
package icu_cascade_pkg;
  localparam int SLICE_LINES = 8;
  localparam int IDX_W       = $clog2(SLICE_LINES);
  localparam int NUM_SLICES  = 2;
  localparam int TOTAL_LINES = SLICE_LINES * NUM_SLICES;
  localparam int GLINE_W     = $clog2(TOTAL_LINES);
  localparam int BASE_W      = 5;
  localparam int VEC_W       = BASE_W + IDX_W;
  localparam int CASC_IDX    = 2;
  localparam int SPUR_IDX    = SLICE_LINES - 1;

  // Lowest set bit of a slice vector; returns 0 for an empty vector.
  function automatic logic [IDX_W-1:0] lowest_idx(input logic [SLICE_LINES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = SLICE_LINES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/icu_resolver_slice.sv
module icu_resolver_slice
  import icu_cascade_pkg::*;
#(
  parameter logic [SLICE_LINES-1:0] PULSE_ONLY = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SLICE_LINES-1:0] line_in,
  input  logic [SLICE_LINES-1:0] pulse_set,
  input  logic [SLICE_LINES-1:0] mask,
  input  logic [SLICE_LINES-1:0] level_sel,
  input  logic                   ack_en,
  input  logic [IDX_W-1:0]       ack_idx,
  input  logic                   eoi_en,
  input  logic [IDX_W-1:0]       eoi_idx,
  output logic                   win_hit,
  output logic [IDX_W-1:0]       win_idx
);
  logic [SLICE_LINES-1:0] irr_q, isr_q, last_q;
  logic [SLICE_LINES-1:0] irr_n, isr_n;
  logic [SLICE_LINES-1:0] line_eff, level_eff, rise, pend;
  logic [IDX_W-1:0]       pend_idx, serv_idx;

  // Pulse-only lines take no external input and are always edge style.
  assign line_eff  = line_in & ~PULSE_ONLY;
  assign level_eff = level_sel & ~PULSE_ONLY;
  assign rise      = line_eff & ~last_q;

  always_comb begin
    irr_n = (level_eff & line_eff) | (~level_eff & (irr_q | rise)) | pulse_set;
    if (ack_en && !level_eff[ack_idx]) irr_n[ack_idx] = 1'b0;
    isr_n = isr_q;
    if (eoi_en) isr_n[eoi_idx] = 1'b0;
    if (ack_en) isr_n[ack_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      last_q <= '0;
    end else begin
      irr_q  <= irr_n;
      isr_q  <= isr_n;
      last_q <= line_eff;
    end
  end

  assign pend     = irr_q & ~mask;
  assign pend_idx = lowest_idx(pend);
  assign serv_idx = lowest_idx(isr_q);
  assign win_hit  = (|pend) && ((isr_q == '0) || (pend_idx < serv_idx));
  assign win_idx  = pend_idx;

  assert_ack_in_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |=> isr_q[$past(ack_idx)]);

  assert_eoi_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_en && !(ack_en && ack_idx == eoi_idx)) |=> !isr_q[$past(eoi_idx)]);

  assert_edge_ack_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && !level_eff[ack_idx]) |=> !irr_q[$past(ack_idx)]);
endmodule

// File: rtl/icu_ack_steer.sv
module icu_ack_steer
  import icu_cascade_pkg::*;
(
  input  logic               m_hit,
  input  logic [IDX_W-1:0]   m_idx,
  input  logic               s_hit,
  input  logic [IDX_W-1:0]   s_idx,
  input  logic [BASE_W-1:0]  master_base,
  input  logic [BASE_W-1:0]  slave_base,
  output logic               m_take,
  output logic               s_take,
  output logic [VEC_W-1:0]   vec,
  output logic [GLINE_W-1:0] gline
);
  localparam logic [IDX_W-1:0] SPUR = IDX_W'(SPUR_IDX);
  localparam logic [IDX_W-1:0] CASC = IDX_W'(CASC_IDX);

  always_comb begin
    m_take = 1'b0;
    s_take = 1'b0;
    vec    = {master_base, SPUR};
    gline  = {1'b0, SPUR};
    if (m_hit) begin
      m_take = 1'b1;
      if (m_idx != CASC) begin
        vec   = {master_base, m_idx};
        gline = {1'b0, m_idx};
      end else if (s_hit) begin
        s_take = 1'b1;
        vec    = {slave_base, s_idx};
        gline  = {1'b1, s_idx};
      end else begin
        vec   = {slave_base, SPUR};
        gline = {1'b1, SPUR};
      end
    end
  end
endmodule

// File: rtl/icu_cascade_ack.sv
module icu_cascade_ack
  import icu_cascade_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TOTAL_LINES-1:0] irq_in,
  input  logic [TOTAL_LINES-1:0] irq_mask,
  input  logic [TOTAL_LINES-1:0] level_sel,
  input  logic [BASE_W-1:0]      master_base,
  input  logic [BASE_W-1:0]      slave_base,
  input  logic                   ack_stb,
  input  logic                   eoi_stb,
  input  logic [GLINE_W-1:0]     eoi_line,
  output logic                   int_req,
  output logic                   vec_valid,
  output logic [VEC_W-1:0]       vec_out,
  output logic [GLINE_W-1:0]     vec_line
);
  localparam logic [SLICE_LINES-1:0] CASC_MASK = SLICE_LINES'(1) << CASC_IDX;

  logic [NUM_SLICES-1:0]            hit_v, take_v, eoi_v;
  logic [NUM_SLICES-1:0][IDX_W-1:0] idx_v;
  logic [SLICE_LINES-1:0]           casc_pulse;
  logic [VEC_W-1:0]                 vec_d;
  logic [GLINE_W-1:0]               gline_d;
  logic                             m_take, s_take;

  // Slave winner reaches master line 2 as a one-cycle set.
  always_comb begin
    casc_pulse           = '0;
    casc_pulse[CASC_IDX] = hit_v[1];
  end

  // Global line bit 3 picks the slice, low bits the line.
  assign eoi_v[0] = eoi_stb && !eoi_line[GLINE_W-1];
  assign eoi_v[1] = eoi_stb &&  eoi_line[GLINE_W-1];
  assign take_v   = {s_take, m_take} & {NUM_SLICES{ack_stb}};

  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
    localparam logic [SLICE_LINES-1:0] PO = (g == 0) ? CASC_MASK : '0;
    icu_resolver_slice #(.PULSE_ONLY(PO)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (irq_in[g*SLICE_LINES +: SLICE_LINES]),
      .pulse_set ((g == 0) ? casc_pulse : '0),
      .mask      (irq_mask[g*SLICE_LINES +: SLICE_LINES]),
      .level_sel (level_sel[g*SLICE_LINES +: SLICE_LINES]),
      .ack_en    (take_v[g]),
      .ack_idx   (idx_v[g]),
      .eoi_en    (eoi_v[g]),
      .eoi_idx   (eoi_line[IDX_W-1:0]),
      .win_hit   (hit_v[g]),
      .win_idx   (idx_v[g])
    );
  end

  icu_ack_steer u_steer (
    .m_hit       (hit_v[0]),
    .m_idx       (idx_v[0]),
    .s_hit       (hit_v[1]),
    .s_idx       (idx_v[1]),
    .master_base (master_base),
    .slave_base  (slave_base),
    .m_take      (m_take),
    .s_take      (s_take),
    .vec         (vec_d),
    .gline       (gline_d)
  );

  assign int_req = hit_v[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_out   <= '0;
      vec_line  <= '0;
    end else begin
      vec_valid <= ack_stb;
      if (ack_stb) begin
        vec_out  <= vec_d;
        vec_line <= gline_d;
      end
    end
  end

  assert_vec_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |=> vec_valid);

  assert_vec_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_stb |=> !vec_valid);

  assert_idle_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && !int_req) |=> (vec_line == GLINE_W'(SPUR_IDX)
      && vec_out == {$past(master_base), IDX_W'(SPUR_IDX)}));

  assert_slave_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_line[GLINE_W-1]) |-> vec_out[VEC_W-1:IDX_W] == $past(slave_base));

  assert_master_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_line[GLINE_W-1]) |-> vec_out[VEC_W-1:IDX_W] == $past(master_base));
endmodule

// File: tb/icu_cascade_ack_test.sv
`timescale 1ns/1ps
module icu_cascade_ack_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] irq_in = '0, irq_mask = '0, level_sel = '0;
  logic [4:0]  master_base = 5'h04, slave_base = 5'h0E;
  logic        ack_stb = 0, eoi_stb = 0;
  logic [3:0]  eoi_line = '0;
  logic        int_req, vec_valid;
  logic [7:0]  vec_out;
  logic [3:0]  vec_line;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  icu_cascade_ack uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_irr = '0, m_isr = '0, m_last = '0;
  logic        e_valid = 0;
  logic [7:0]  e_vec = '0;
  logic [3:0]  e_line = '0;

  function automatic logic [3:0] pick(input logic [7:0] irr, input logic [7:0] isr,
                                      input logic [7:0] msk);
    int p, s;
    p = 8; s = 8;
    for (int i = 7; i >= 0; i--) begin
      if (irr[i] && !msk[i]) p = i;
      if (isr[i]) s = i;
    end
    if (p < s) return {1'b1, 3'(p)};
    return 4'b0;
  endfunction

  always @(posedge clk) begin
    logic [3:0]  mw, sw;
    logic [15:0] nirr, nisr;
    int ma, sa;
    if (!rst_n) begin
      m_irr = '0; m_isr = '0; m_last = '0; e_valid = 0;
    end else begin
      mw = pick(m_irr[7:0], m_isr[7:0], irq_mask[7:0]);
      sw = pick(m_irr[15:8], m_isr[15:8], irq_mask[15:8]);
      ma = -1; sa = -1;
      e_valid = ack_stb;
      if (ack_stb) begin
        if (!mw[3]) begin
          e_vec = {master_base, 3'd7}; e_line = 4'd7;
        end else if (mw[2:0] != 3'd2) begin
          ma = mw[2:0]; e_vec = {master_base, mw[2:0]}; e_line = {1'b0, mw[2:0]};
        end else if (sw[3]) begin
          ma = 2; sa = 8 + sw[2:0];
          e_vec = {slave_base, sw[2:0]}; e_line = {1'b1, sw[2:0]};
        end else begin
          ma = 2; e_vec = {slave_base, 3'd7}; e_line = 4'd15;
        end
      end
      for (int i = 0; i < 16; i++) begin
        if (i == 2) nirr[i] = m_irr[i] | sw[3];
        else if (level_sel[i]) nirr[i] = irq_in[i];
        else nirr[i] = m_irr[i] | (irq_in[i] & ~m_last[i]);
      end
      nisr = m_isr;
      if (eoi_stb) nisr[eoi_line] = 1'b0;
      if (ma >= 0) begin
        nisr[ma] = 1'b1;
        if (ma == 2 || !level_sel[ma]) nirr[ma] = 1'b0;
      end
      if (sa >= 0) begin
        nisr[sa] = 1'b1;
        if (!level_sel[sa]) nirr[sa] = 1'b0;
      end
      m_irr = nirr; m_isr = nisr; m_last = irq_in;
    end
  end

  always @(negedge clk) begin
    logic [3:0] mw;
    if (rst_n && !done) begin
      mw = pick(m_irr[7:0], m_isr[7:0], irq_mask[7:0]);
      chk(int_req == mw[3], "R3 model int_req", int_req, mw[3]);
      chk(vec_valid == e_valid, "R9 model vec_valid", vec_valid, e_valid);
      if (e_valid) begin
        chk(vec_out == e_vec, "R5 model vec_out", vec_out, e_vec);
        chk(vec_line == e_line, "R5 model vec_line", vec_line, e_line);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic want_req(input bit exp, input string tag);
    @(negedge clk);
    chk(int_req == exp, tag, int_req, exp);
    @(posedge clk); #1;
  endtask

  task automatic do_ack(input logic [7:0] xv, input logic [3:0] xl, input string tag);
    ack_stb = 1;
    @(posedge clk); #1;
    ack_stb = 0;
    @(negedge clk);
    chk(vec_valid == 1'b1, {tag, " valid"}, vec_valid, 1);
    chk(vec_out == xv, {tag, " vec"}, vec_out, xv);
    chk(vec_line == xl, {tag, " line"}, vec_line, xl);
    @(negedge clk);
    chk(vec_valid == 1'b0, "R9 single pulse", vec_valid, 0);
    @(posedge clk); #1;
  endtask

  task automatic do_eoi(input logic [3:0] l);
    eoi_stb = 1; eoi_line = l;
    step(1);
    eoi_stb = 0;
    step(1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(int_req == 0, "R1 reset int_req", int_req, 0);
    chk(vec_valid == 0, "R1 reset vec_valid", vec_valid, 0);
    @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    chk(int_req == 0 && vec_valid == 0, "R1 after reset", {int_req, vec_valid}, 0);
    step(1);

    // R5 single master line
    irq_in[5] = 1; step(2);
    want_req(1, "R2 edge latched");
    do_ack(8'h25, 4'd5, "R5 line5");
    irq_in[5] = 0; step(1);
    want_req(0, "R3 none pending");
    // R3 preemption and blocking
    irq_in[3] = 1; step(2);
    want_req(1, "R3 higher preempts");
    do_ack(8'h23, 4'd3, "R5 line3");
    irq_in[6] = 1; step(2);
    want_req(0, "R3 lower blocked");
    do_eoi(4'd3);
    want_req(0, "R3 still blocked by 5");
    do_eoi(4'd5);
    want_req(1, "R10 eoi releases 6");
    do_ack(8'h26, 4'd6, "R5 line6");
    do_eoi(4'd6);
    irq_in[3] = 0; irq_in[6] = 0; step(1);

    // R2 mask
    irq_mask[1] = 1; irq_in[1] = 1; step(2);
    want_req(0, "R2 masked");
    irq_mask[1] = 0; step(1);
    want_req(1, "R2 unmask shows pending");
    do_ack(8'h21, 4'd1, "R5 line1");
    do_eoi(4'd1);
    irq_in[1] = 0;
    // R2 held high no re-request
    irq_in[0] = 1; step(2);
    do_ack(8'h20, 4'd0, "R5 line0");
    do_eoi(4'd0); step(2);
    want_req(0, "R2 held high no repeat");
    irq_in[0] = 0; step(1);

    // R4 external line 2 ignored
    level_sel[2] = 1; irq_in[2] = 1; step(3);
    want_req(0, "R4 irq_in2 ignored");
    irq_in[2] = 0; level_sel[2] = 0; step(1);

    // R6 slave line 12 through cascade
    irq_in[12] = 1; step(4);
    want_req(1, "R4 cascade raises");
    do_ack(8'h74, 4'd12, "R6 line12");
    irq_in[3] = 1; step(2);
    want_req(0, "R3 master2 blocks 3");
    do_eoi(4'd12);
    want_req(0, "R10 slave eoi leaves master");
    do_eoi(4'd2);
    want_req(1, "R10 master eoi");
    do_ack(8'h23, 4'd3, "R5 line3 again");
    do_eoi(4'd3);
    irq_in[3] = 0; irq_in[12] = 0; step(1);

    // R7 slave request vanishes
    level_sel[9] = 1; irq_in[9] = 1; step(4);
    irq_in[9] = 0; step(2);
    want_req(1, "R7 master2 stays");
    do_ack(8'h77, 4'd15, "R7 slave spurious");
    do_eoi(4'd2);
    level_sel[9] = 0;
    want_req(0, "R7 quiet after");

    // R8 nothing pending
    do_ack(8'h27, 4'd7, "R8 master spurious");

    // R11 level line stays pending
    level_sel[4] = 1; irq_in[4] = 1; step(2);
    do_ack(8'h24, 4'd4, "R11 level ack");
    do_eoi(4'd4);
    want_req(1, "R11 level still pending");
    do_ack(8'h24, 4'd4, "R11 level ack2");
    irq_in[4] = 0; do_eoi(4'd4);
    want_req(0, "R11 level dropped");
    level_sel = '0;

    // random traffic compared against the model
    level_sel = 16'h0a31 & 16'hfffb;
    for (int c = 0; c < 4000; c++) begin
      if (c % 64 == 0) irq_mask = 16'($urandom) & 16'h3c3c;
      irq_in   = irq_in ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
      ack_stb  = ($urandom % 6) == 0;
      eoi_stb  = ($urandom % 5) == 0;
      eoi_line = 4'($urandom);
      step(1);
    end
    ack_stb = 0; eoi_stb = 0;
    step(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule